// File: doc/BRIEF.md
# Power-up Reset Time-out Sequencer

This block decides when the core may leave reset after a power-on event, a brown-out event or a wake from sleep. Once the event pulse has ended, it can run a power-up delay and then an oscillator start-up delay. The power-up delay always comes first. The oscillator mode and a power-up-delay enable input decide which of the two delays are used. Only one sequence runs at a time. A fresh power-on or brown-out pulse aborts any sequence in progress and starts over.

The external master-clear pin does not stop the delays. It only gates the final release. If the pin is held low for longer than the delays, the core leaves reset two clock edges after the pin goes high. The pin passes through a two-flop synchronizer first.

Top module: `reset_timeout_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until a power-on or brown-out sequence completes, both `timeout_done_o` and `core_rst_n_o` are low.
- R2: In a crystal mode (`osc_mode_i` 0, 1 or 2) with `pwrt_en_i`=1, `timeout_done_o` first reads high after the (1+PWRT_CYC+OST_CYC)-th rising edge. Edges are counted from the first edge that samples the event pulse low. The power-up delay runs before the start-up delay.
- R3: In a crystal mode with `pwrt_en_i`=0, the release comes after the (1+OST_CYC)-th such edge.
- R4: In any other mode (`osc_mode_i` 3 to 7) with `pwrt_en_i`=1, the release comes after the (1+PWRT_CYC)-th such edge.
- R5: In a non-crystal mode with `pwrt_en_i`=0, the release comes after the first such edge.
- R6: A brown-out pulse follows exactly the same delay rules as a power-on pulse.
- R7: A one-cycle `wake_i` pulse that arrives while `timeout_done_o` is high in a crystal mode drives `timeout_done_o` low on the next edge. It reads high again after the (1+OST_CYC)-th edge, counting the wake edge as the first.
- R8: `wake_i` has no effect in a non-crystal mode, and no effect while a sequence is running. In those cases `timeout_done_o` and the release time are unchanged.
- R9: A power-on or brown-out pulse that arrives during a sequence, or on the very edge that would finish it, makes `timeout_done_o` low on the next edge. It then restarts the full delay.
- R10: `core_rst_n_o` is high only when `timeout_done_o` is high and `mclr_n_i` was high two edges earlier. The delays keep running while `mclr_n_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_pulse_i | input | 1 | Power-on event, active high |
| bor_pulse_i | input | 1 | Brown-out event, active high |
| wake_i | input | 1 | Wake-from-sleep event, one cycle |
| mclr_n_i | input | 1 | External master clear, active low, asynchronous |
| osc_mode_i | input | 3 | Oscillator mode: 0..2 crystal types, 3..7 other |
| pwrt_en_i | input | 1 | Enables the power-up delay |
| core_rst_n_o | output | 1 | Core reset release, high = run |
| timeout_done_o | output | 1 | All applicable delays have expired |

## Verification
The sharpest collision is a brown-out pulse on the very edge where the start-up count reaches its end, so that "finish" and "restart" fall in the same cycle. The bench counts edges from the end of a power-on pulse and raises the brown-out input just before the final edge. It then requires `timeout_done_o` to stay low and a complete new delay to follow. A second overlap is a wake pulse that lands inside a running power-up delay. That case is judged by checking that the release edge does not move.

// File: rtl/rto_pkg.sv
// Shared types for the reset time-out sequencer.
// Assumes oscillator mode codes 0..2 are crystal-type, everything else is not.
package rto_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE = 3'd0,   // waiting for the first power event
        SEQ_HOLD = 3'd1,   // event pulse still asserted
        SEQ_PWRT = 3'd2,   // power-up delay running
        SEQ_OST  = 3'd3,   // oscillator start-up delay running
        SEQ_DONE = 3'd4    // all delays expired
    } seq_state_t;

    localparam logic [2:0] LAST_CRYSTAL_MODE = 3'd2;

    function automatic logic is_crystal(input logic [2:0] mode);
        return mode <= LAST_CRYSTAL_MODE;
    endfunction

endpackage

// File: rtl/rto_sync2.sv
// Two-flop synchronizer for one asynchronous level.
// Assumes the input is a slow level; resets to 0 (reset asserted).
module rto_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;

    // Shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q_o    <= 1'b0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/rto_cycle_counter.sv
// Shared cycle counter for both delays.
// Assumes the controller clears it on every state change; it holds when not running.
module rto_cycle_counter #(
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    output logic [WIDTH-1:0] count_o
);
    // Clear on request, otherwise count while a delay runs.
    always_ff @(posedge clk) begin
        if (!rst_n)     count_o <= '0;
        else if (clr_i) count_o <= '0;
        else if (run_i) count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/rto_seq_fsm.sv
// Sequencing state machine: chooses and orders the delays.
// Assumes PWRT_CYC and OST_CYC are at least 1 and the mode is stable during a sequence.
module rto_seq_fsm
    import rto_pkg::*;
#(
    parameter int PWRT_CYC = 4096,
    parameter int OST_CYC  = 1024,
    parameter int CW       = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          wake_i,
    input  logic          crystal_i,
    input  logic          pwrt_en_i,
    input  logic [CW-1:0] count_i,
    output logic          clr_o,
    output logic          run_o,
    output logic          done_o
);
    localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_CYC - 1);
    localparam logic [CW-1:0] OST_LAST  = CW'(OST_CYC - 1);

    seq_state_t state_q, state_d, first_step;
    logic       pwrt_last, ost_last;

    assign pwrt_last = (count_i == PWRT_LAST);
    assign ost_last  = (count_i == OST_LAST);

    // Pick the first delay once the event pulse has ended.
    always_comb begin
        if (pwrt_en_i)      first_step = SEQ_PWRT;
        else if (crystal_i) first_step = SEQ_OST;
        else                first_step = SEQ_DONE;
    end

    // Next-state rules; a power event always wins.
    always_comb begin
        state_d = state_q;
        if (restart_i) begin
            state_d = SEQ_HOLD;
        end else begin
            case (state_q)
                SEQ_IDLE: state_d = SEQ_IDLE;
                SEQ_HOLD: state_d = first_step;
                SEQ_PWRT: if (pwrt_last) state_d = crystal_i ? SEQ_OST : SEQ_DONE;
                SEQ_OST:  if (ost_last)  state_d = SEQ_DONE;
                SEQ_DONE: if (wake_i && crystal_i) state_d = SEQ_OST;
                default:  state_d = SEQ_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assign clr_o  = (state_d != state_q);
    assign run_o  = (state_q == SEQ_PWRT) || (state_q == SEQ_OST);
    assign done_o = (state_q == SEQ_DONE);

    // R9: any power event blocks completion on the following edge.
    p_restart_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !done_o);

    // R8: a wake outside crystal modes leaves the finished state alone.
    p_wake_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && wake_i && !crystal_i && !restart_i) |=> done_o);

    // R2: the power-up count never runs past its length.
    p_pwrt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_PWRT) |-> (count_i <= PWRT_LAST));

    // R7: the start-up count never runs past its length.
    p_ost_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_OST) |-> (count_i <= OST_LAST));

    // R3: the start-up delay is only entered in a crystal mode.
    p_ost_crystal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_OST && $past(state_q) != SEQ_OST) |-> $past(crystal_i));
endmodule

// File: rtl/reset_timeout_seq.sv
// Top: power-up reset time-out sequencer.
// Assumes pulses are synchronous to clk; only mclr_n_i is asynchronous.
module reset_timeout_seq #(
    parameter int PWRT_CYC = 4096,
    parameter int OST_CYC  = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_pulse_i,
    input  logic       bor_pulse_i,
    input  logic       wake_i,
    input  logic       mclr_n_i,
    input  logic [2:0] osc_mode_i,
    input  logic       pwrt_en_i,
    output logic       core_rst_n_o,
    output logic       timeout_done_o
);
    localparam int MAX_CYC = (PWRT_CYC > OST_CYC) ? PWRT_CYC : OST_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic          mclr_sync;
    logic          clr, run;
    logic [CW-1:0] count;

    rto_sync2 u_mclr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (mclr_n_i),
        .q_o   (mclr_sync)
    );

    rto_cycle_counter #(.WIDTH(CW)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .run_i   (run),
        .count_o (count)
    );

    rto_seq_fsm #(.PWRT_CYC(PWRT_CYC), .OST_CYC(OST_CYC), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (por_pulse_i | bor_pulse_i),
        .wake_i    (wake_i),
        .crystal_i (rto_pkg::is_crystal(osc_mode_i)),
        .pwrt_en_i (pwrt_en_i),
        .count_i   (count),
        .clr_o     (clr),
        .run_o     (run),
        .done_o    (timeout_done_o)
    );

    assign core_rst_n_o = timeout_done_o & mclr_sync;

    // R10: release needs the pin high two edges earlier.
    p_mclr_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_n_o |-> $past(mclr_n_i, 2));
endmodule

// File: tb/tb_reset_timeout_seq.sv
module tb_reset_timeout_seq;
    localparam int P = 20;
    localparam int O = 1024;
    localparam int EV_POR = 0, EV_BOR = 1, EV_WAKE = 2;

    typedef struct packed {
        int ev;
        int mode;
        int en;
        int lat;
        int req;
    } vec_t;

    // Table walk: R2 R3 R4 R5 R6 R7 R8
    localparam vec_t TBL [14] = '{
        '{EV_POR, 0, 1, P+O+1, 2}, '{EV_POR, 1, 1, P+O+1, 2},
        '{EV_POR, 2, 0, O+1, 3},   '{EV_POR, 0, 0, O+1, 3},
        '{EV_POR, 3, 1, P+1, 4},   '{EV_POR, 5, 1, P+1, 4},
        '{EV_POR, 4, 0, 1, 5},     '{EV_POR, 7, 0, 1, 5},
        '{EV_BOR, 2, 1, P+O+1, 6}, '{EV_BOR, 4, 1, P+1, 6},
        '{EV_WAKE, 1, 1, O+1, 7},  '{EV_WAKE, 0, 0, O+1, 7},
        '{EV_WAKE, 3, 1, 1, 8},    '{EV_WAKE, 4, 0, 1, 8}
    };

    logic clk = 0, rst_n = 0, por = 0, bor = 0, wake = 0, mclr_n = 1, pwrt_en = 0;
    logic [2:0] mode = 0;
    logic core_rst_n, done;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    reset_timeout_seq #(.PWRT_CYC(P), .OST_CYC(O)) dut (
        .clk(clk), .rst_n(rst_n), .por_pulse_i(por), .bor_pulse_i(bor),
        .wake_i(wake), .mclr_n_i(mclr_n), .osc_mode_i(mode), .pwrt_en_i(pwrt_en),
        .core_rst_n_o(core_rst_n), .timeout_done_o(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulse an event at the negedge; return edges until done is seen high.
    task automatic run_event(input int ev, output int n);
        n = 0;
        if (ev == EV_WAKE) begin
            wake = 1;
        end else begin
            if (ev == EV_POR) por = 1; else bor = 1;
            @(posedge clk); @(negedge clk);
            por = 0; bor = 0;
        end
        forever begin
            @(posedge clk); n++;
            @(negedge clk);
            wake = 0;
            if (done || n > 5000) break;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: outputs low in reset
        check("R1 done in reset", done, 0);
        check("R1 release in reset", core_rst_n, 0);
        rst_n = 1;
        repeat (5) @(negedge clk);
        check("R1 done before any event", done, 0);
        check("R1 release before any event", core_rst_n, 0);

        foreach (TBL[i]) begin
            mode = 3'(TBL[i].mode);
            pwrt_en = TBL[i].en[0];
            if (TBL[i].ev == EV_WAKE) run_event(EV_POR, n);
            run_event(TBL[i].ev, n);
            check($sformatf("R%0d latency vector %0d", TBL[i].req, i), n, TBL[i].lat);
            repeat (2) @(negedge clk);
            check($sformatf("R%0d release vector %0d", TBL[i].req, i), core_rst_n, 1);
        end

        // R9: brown-out on the edge that would finish the sequence
        mode = 1; pwrt_en = 1;
        por = 1; @(posedge clk); @(negedge clk); por = 0;
        repeat (P+O) @(negedge clk);
        check("R9 not done one edge early", done, 0);
        bor = 1;
        @(negedge clk);
        check("R9 collision keeps done low", done, 0);
        bor = 0;
        n = 0;
        forever begin
            @(posedge clk); n++; @(negedge clk);
            if (done || n > 5000) break;
        end
        check("R9 full delay after collision", n, P+O+1);

        // R9: power-on in the middle of the power-up delay restarts it
        por = 1; @(posedge clk); @(negedge clk); por = 0;
        repeat (10) @(negedge clk);
        run_event(EV_POR, n);
        check("R9 mid-run restart latency", n, P+O+1);

        // R8: wake during a running sequence does not shift the release
        por = 1; @(posedge clk); @(negedge clk); por = 0;
        n = 0;
        forever begin
            @(posedge clk); n++; @(negedge clk);
            wake = (n == 5);
            if (done || n > 5000) break;
        end
        check("R8 wake mid-run latency", n, P+O+1);
        wake = 0;

        // R10: pin held low past the time-outs, release two edges after rising
        mode = 3; pwrt_en = 1; mclr_n = 0;
        run_event(EV_POR, n);
        check("R10 delays run with pin low", n, P+1);
        repeat (3) @(negedge clk);
        check("R10 held by pin", core_rst_n, 0);
        mclr_n = 1;
        @(negedge clk);
        check("R10 one edge after pin high", core_rst_n, 0);
        @(negedge clk);
        check("R10 two edges after pin high", core_rst_n, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule